// File: doc/BRIEF.md
# Mirrored System Address Decoder

This block sits between an 8-bit processor and the devices on its 16-bit address bus. Each cycle it classifies the address into a region and raises the matching chip select, together with a local register index folded from the address. It holds a 2 KiB work RAM that repeats four times across the lowest 8 KiB. A bank of eight video registers repeats every 8 bytes up to 0x3FFF. A small I/O window serves an audio register bank, two serial controller ports and a DMA trigger, and everything from 0x4020 upwards goes to an external cartridge port. In the I/O window a read and a write to the same address can reach different targets.

Read data is gathered from the selected source and registered, so it appears one cycle after the read. Write data goes to every target on a shared write bus. Each target acts on it only while its own select is high.

Two small state machines run beside the decoder. The interrupt watcher has the states WATCH_IDLE and WATCH_CHECK. A video write moves it to WATCH_CHECK, or keeps it there, and it records the video unit's interrupt-enable bit as it stood before the write. A cycle with no video write returns it to WATCH_IDLE. In WATCH_CHECK it raises `nmi_req` if the enable bit now reads 1, was 0 before the write, and vblank is active. The error tracker has the states ERR_CLEAR and ERR_LATCHED. Any read or write in 0x4018–0x401F moves it to ERR_LATCHED, and only reset brings it back to ERR_CLEAR.

Top module: `sysbus_decoder`

## Requirements
- R1: Addresses 0x0000–0x1FFF reach the internal RAM at index (address mod 2048). A byte written through any mirror reads back through every other mirror.
- R2: Addresses 0x2000–0x3FFF raise `vid_sel` with `vid_idx` = address mod 8. A read there returns `vid_rdata`. At most one target select, including the test-range hit, is high in any cycle.
- R3: A read of 0x4016 pulses `pad0_rd` and returns `pad0_rdata`. A read of 0x4017 pulses `pad1_rd` and returns `pad1_rdata`. Neither read selects audio.
- R4: A read of 0x4000–0x4015 raises `apu_sel` with `apu_idx` = address bits 4:0 and returns `apu_rdata`.
- R5: A write to 0x4016 raises `pad_strobe_wr` with `pad_strobe` = write data bit 0, and does not raise `apu_sel`.
- R6: A write to 0x4014 raises `dma_start` with `dma_page` = the write data, and does not raise `apu_sel`.
- R7: Every other write in 0x4000–0x4017, including 0x4017, raises `apu_sel` with `apu_idx` = address bits 4:0. `bus_wdata` carries the write data.
- R8: Any read or write in 0x4018–0x401F sets `test_err` from the next cycle on, and it stays set until reset. A read there returns 0x00. Accesses outside this range leave `test_err` at 0.
- R9: Addresses 0x4020–0xFFFF raise `cart_sel` with `cart_addr` equal to the full address. A read there returns `cart_rdata`.
- R10: In the cycle after a video write, `nmi_req` is high for exactly that cycle if `vid_nmi_en` was 0 during the write cycle, `vid_nmi_en` is now 1 and `vid_vblank` is 1. Otherwise it stays low.
- R11: After reset, `cpu_rdata` is 0x00 and `test_err` and `nmi_req` are 0.
- R12: `cpu_rdata` changes only on the clock edge that ends a read cycle (`cpu_rd`=1, `cpu_wr`=0). It holds its value through write and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read strobe for this cycle |
| cpu_wr | input | 1 | Write strobe for this cycle (takes priority over read) |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Registered read data |
| bus_wr | output | 1 | Write strobe forwarded to targets |
| bus_wdata | output | 8 | Write data forwarded to targets |
| vid_sel | output | 1 | Video register bank select |
| vid_idx | output | 3 | Folded video register index |
| vid_rdata | input | 8 | Video read data |
| vid_nmi_en | input | 1 | Video interrupt-enable bit, current value |
| vid_vblank | input | 1 | Video vblank-active status |
| apu_sel | output | 1 | Audio register bank select |
| apu_idx | output | 5 | Audio register index |
| apu_rdata | input | 8 | Audio read data |
| pad0_rd | output | 1 | Read pulse for controller port 0 |
| pad1_rd | output | 1 | Read pulse for controller port 1 |
| pad0_rdata | input | 8 | Controller port 0 data |
| pad1_rdata | input | 8 | Controller port 1 data |
| pad_strobe_wr | output | 1 | Strobe write to both controller ports |
| pad_strobe | output | 1 | Strobe level |
| dma_start | output | 1 | DMA trigger pulse |
| dma_page | output | 8 | DMA source page |
| cart_sel | output | 1 | Cartridge space select |
| cart_addr | output | 16 | Cartridge address |
| cart_rdata | input | 8 | Cartridge read data |
| nmi_req | output | 1 | Non-maskable interrupt request |
| test_err | output | 1 | Sticky test-range access flag |

## Verification
The bench builds the block with its default parameters: 2048 RAM bytes, eight video registers and a 5-bit audio index. This configuration is small enough that every one of the 65,536 addresses can be read in one sweep. Each select, folded index and registered data byte is compared with a value the bench computes from the address. The RAM is first filled through rotating mirrors, so the sweep also shows the modulo-2048 folding across all four copies. Writes are swept over the whole I/O window, and the read-versus-write differences and the interrupt corner cases (enable already set, vblank off, writes to a mirror, writes to another register) are driven one at a time.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;

    localparam int MAP_AW = 16;

    localparam logic [MAP_AW-1:0] MAP_VID_BASE  = 16'h2000;
    localparam logic [MAP_AW-1:0] MAP_IO_BASE   = 16'h4000;
    localparam logic [MAP_AW-1:0] MAP_TEST_BASE = 16'h4018;
    localparam logic [MAP_AW-1:0] MAP_CART_BASE = 16'h4020;
    localparam logic [MAP_AW-1:0] MAP_DMA_REG   = 16'h4014;
    localparam logic [MAP_AW-1:0] MAP_PAD0_REG  = 16'h4016;
    localparam logic [MAP_AW-1:0] MAP_PAD1_REG  = 16'h4017;

    typedef enum logic [3:0] {
        RGN_RAM,
        RGN_VID,
        RGN_APU,
        RGN_PAD0,
        RGN_PAD1,
        RGN_STROBE,
        RGN_DMA,
        RGN_TEST,
        RGN_CART
    } region_e;

    typedef enum logic {
        WATCH_IDLE,
        WATCH_CHECK
    } watch_state_e;

    typedef enum logic {
        ERR_CLEAR,
        ERR_LATCHED
    } err_state_e;

endpackage

// File: rtl/sysbus_region_decode.sv
module sysbus_region_decode
    import sysbus_pkg::*;
(
    input  logic [MAP_AW-1:0] addr_i,
    input  logic              wr_i,
    output region_e           region_o
);

    always_comb begin
        if (addr_i < MAP_VID_BASE) begin
            region_o = RGN_RAM;
        end else if (addr_i < MAP_IO_BASE) begin
            region_o = RGN_VID;
        end else if (addr_i < MAP_TEST_BASE) begin
            if (addr_i == MAP_PAD0_REG) begin
                region_o = wr_i ? RGN_STROBE : RGN_PAD0;
            end else if (addr_i == MAP_PAD1_REG) begin
                region_o = wr_i ? RGN_APU : RGN_PAD1;
            end else if (addr_i == MAP_DMA_REG && wr_i) begin
                region_o = RGN_DMA;
            end else begin
                region_o = RGN_APU;
            end
        end else if (addr_i < MAP_CART_BASE) begin
            region_o = RGN_TEST;
        end else begin
            region_o = RGN_CART;
        end
    end

endmodule

// File: rtl/sysbus_work_ram.sv
module sysbus_work_ram #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/sysbus_nmi_watch.sv
module sysbus_nmi_watch
    import sysbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vid_wr_i,
    input  logic en_i,
    input  logic vblank_i,
    output logic nmi_req_o
);

    watch_state_e state_q, state_d;
    logic         en_before_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= WATCH_IDLE;
            en_before_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (vid_wr_i) begin
                en_before_q <= en_i;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            WATCH_IDLE:  state_d = vid_wr_i ? WATCH_CHECK : WATCH_IDLE;
            WATCH_CHECK: state_d = vid_wr_i ? WATCH_CHECK : WATCH_IDLE;
            default:     state_d = WATCH_IDLE;
        endcase
    end

    always_comb begin
        nmi_req_o = 1'b0;
        unique case (state_q)
            WATCH_IDLE:  nmi_req_o = 1'b0;
            WATCH_CHECK: nmi_req_o = !en_before_q && en_i && vblank_i;
            default:     nmi_req_o = 1'b0;
        endcase
    end

    AST_NMI_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_o |=> !nmi_req_o); // R10

endmodule

// File: rtl/sysbus_err_track.sv
module sysbus_err_track
    import sysbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic err_o
);

    err_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ERR_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ERR_CLEAR:   state_d = hit_i ? ERR_LATCHED : ERR_CLEAR;
            ERR_LATCHED: state_d = ERR_LATCHED;
            default:     state_d = ERR_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ERR_CLEAR:   err_o = 1'b0;
            ERR_LATCHED: err_o = 1'b1;
            default:     err_o = 1'b0;
        endcase
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R8

endmodule

// File: rtl/sysbus_decoder.sv
module sysbus_decoder
    import sysbus_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RAM_BYTES = 2048,
    parameter int VID_REGS  = 8,
    parameter int APU_REGS  = 32,
    localparam int RAM_AW   = $clog2(RAM_BYTES),
    localparam int VID_AW   = $clog2(VID_REGS),
    localparam int APU_AW   = $clog2(APU_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAP_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              vid_sel,
    output logic [VID_AW-1:0] vid_idx,
    input  logic [DATA_W-1:0] vid_rdata,
    input  logic              vid_nmi_en,
    input  logic              vid_vblank,
    output logic              apu_sel,
    output logic [APU_AW-1:0] apu_idx,
    input  logic [DATA_W-1:0] apu_rdata,
    output logic              pad0_rd,
    output logic              pad1_rd,
    input  logic [DATA_W-1:0] pad0_rdata,
    input  logic [DATA_W-1:0] pad1_rdata,
    output logic              pad_strobe_wr,
    output logic              pad_strobe,
    output logic              dma_start,
    output logic [DATA_W-1:0] dma_page,
    output logic              cart_sel,
    output logic [MAP_AW-1:0] cart_addr,
    input  logic [DATA_W-1:0] cart_rdata,
    output logic              nmi_req,
    output logic              test_err
);

    region_e           region;
    logic              access;
    logic              rd_acc;
    logic              ram_we;
    logic              test_hit;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    assign access = cpu_rd | cpu_wr;
    assign rd_acc = cpu_rd & ~cpu_wr;

    sysbus_region_decode u_decode (
        .addr_i   (cpu_addr),
        .wr_i     (cpu_wr),
        .region_o (region)
    );

    // Target selects, one per region, qualified by an active access
    always_comb begin
        vid_sel       = 1'b0;
        apu_sel       = 1'b0;
        pad0_rd       = 1'b0;
        pad1_rd       = 1'b0;
        pad_strobe_wr = 1'b0;
        dma_start     = 1'b0;
        cart_sel      = 1'b0;
        ram_we        = 1'b0;
        test_hit      = 1'b0;
        unique case (region)
            RGN_RAM:    ram_we        = cpu_wr;
            RGN_VID:    vid_sel       = access;
            RGN_APU:    apu_sel       = access;
            RGN_PAD0:   pad0_rd       = rd_acc;
            RGN_PAD1:   pad1_rd       = rd_acc;
            RGN_STROBE: pad_strobe_wr = cpu_wr;
            RGN_DMA:    dma_start     = cpu_wr;
            RGN_TEST:   test_hit      = access;
            RGN_CART:   cart_sel      = access;
            default:    ;
        endcase
    end

    // Folded local addresses and forwarded write data
    assign vid_idx    = cpu_addr[VID_AW-1:0];
    assign apu_idx    = cpu_addr[APU_AW-1:0];
    assign cart_addr  = cpu_addr;
    assign bus_wr     = cpu_wr;
    assign bus_wdata  = cpu_wdata;
    assign pad_strobe = cpu_wdata[0];
    assign dma_page   = cpu_wdata;

    sysbus_work_ram #(
        .DEPTH  (RAM_BYTES),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .addr_i  (cpu_addr[RAM_AW-1:0]),
        .wdata_i (cpu_wdata),
        .rdata_o (ram_rdata)
    );

    // Read return path, registered
    always_comb begin
        rdata_d = '0;
        unique case (region)
            RGN_RAM:  rdata_d = ram_rdata;
            RGN_VID:  rdata_d = vid_rdata;
            RGN_APU:  rdata_d = apu_rdata;
            RGN_PAD0: rdata_d = pad0_rdata;
            RGN_PAD1: rdata_d = pad1_rdata;
            RGN_CART: rdata_d = cart_rdata;
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_acc) begin
            rdata_q <= rdata_d;
        end
    end

    assign cpu_rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(cpu_rdata)); // R12

    sysbus_nmi_watch u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .vid_wr_i  (vid_sel & cpu_wr),
        .en_i      (vid_nmi_en),
        .vblank_i  (vid_vblank),
        .nmi_req_o (nmi_req)
    );

    sysbus_err_track u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (test_hit),
        .err_o (test_err)
    );

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vid_sel, apu_sel, cart_sel, pad0_rd, pad1_rd,
                  pad_strobe_wr, dma_start, test_hit})); // R2
    AST_CART_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        cart_sel |-> (cart_addr == cpu_addr)); // R9
    AST_DMA_NOT_AUDIO: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (cpu_wr && !apu_sel)); // R6
    AST_STROBE_NOT_AUDIO: assert property (@(posedge clk) disable iff (!rst_n)
        pad_strobe_wr |-> (cpu_wr && !apu_sel)); // R5

endmodule

// File: tb/sysbus_decoder_tb.sv
`timescale 1ns/1ps
module sysbus_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic        vid_sel;
    logic [2:0]  vid_idx;
    logic [7:0]  vid_rdata;
    logic        vid_nmi_en, vid_vblank;
    logic        apu_sel;
    logic [4:0]  apu_idx;
    logic [7:0]  apu_rdata;
    logic        pad0_rd, pad1_rd;
    logic [7:0]  pad0_rdata, pad1_rdata;
    logic        pad_strobe_wr, pad_strobe, dma_start;
    logic [7:0]  dma_page;
    logic        cart_sel;
    logic [15:0] cart_addr;
    logic [7:0]  cart_rdata;
    logic        nmi_req, test_err;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    // Device models outside the block
    logic [7:0] vregs [8];
    assign vid_rdata  = {5'b10110, vid_idx};
    assign apu_rdata  = {3'b011, apu_idx};
    assign pad0_rdata = 8'h5A;
    assign pad1_rdata = 8'hC3;
    assign cart_rdata = cart_addr[15:8] ^ cart_addr[7:0];
    assign vid_nmi_en = vregs[0][7];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) vregs[i] <= 8'h00;
        end else if (vid_sel && bus_wr) begin
            vregs[vid_idx] <= bus_wdata;
        end
    end

    sysbus_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .vid_sel(vid_sel),
        .vid_idx(vid_idx), .vid_rdata(vid_rdata), .vid_nmi_en(vid_nmi_en),
        .vid_vblank(vid_vblank), .apu_sel(apu_sel), .apu_idx(apu_idx),
        .apu_rdata(apu_rdata), .pad0_rd(pad0_rd), .pad1_rd(pad1_rd),
        .pad0_rdata(pad0_rdata), .pad1_rdata(pad1_rdata),
        .pad_strobe_wr(pad_strobe_wr), .pad_strobe(pad_strobe),
        .dma_start(dma_start), .dma_page(dma_page), .cart_sel(cart_sel),
        .cart_addr(cart_addr), .cart_rdata(cart_rdata), .nmi_req(nmi_req),
        .test_err(test_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ram_pat(input int idx);
        return 8'((idx * 7) + ((idx >> 8) * 3) + 1);
    endfunction

    // 0 RAM 1 VID 2 APU 3 PAD0 4 PAD1 5 STROBE 6 DMA 7 TEST 8 CART
    function automatic int region_of(input logic [15:0] a, input bit w);
        if (a < 16'h2000) return 0;
        if (a < 16'h4000) return 1;
        if (a == 16'h4016) return w ? 5 : 3;
        if (a == 16'h4017) return w ? 2 : 4;
        if (a == 16'h4014 && w) return 6;
        if (a < 16'h4018) return 2;
        if (a < 16'h4020) return 7;
        return 8;
    endfunction

    function automatic string tag_of(input int r);
        case (r)
            0: return "R1";
            1: return "R2";
            2: return "R4/R7";
            3, 4: return "R3";
            5: return "R5";
            6: return "R6";
            7: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        case (region_of(a, 1'b0))
            0: return ram_pat(int'(a) % 2048);
            1: return {5'b10110, a[2:0]};
            2: return {3'b011, a[4:0]};
            3: return 8'h5A;
            4: return 8'hC3;
            7: return 8'h00;
            default: return a[15:8] ^ a[7:0];
        endcase
    endfunction

    // Checks selects and folded fields while the access is on the bus
    task automatic check_sel(input logic [15:0] a, input bit w, input logic [7:0] d);
        int r = region_of(a, w);
        logic [6:0] act_f, exp_f;
        bit ok;
        act_f = {vid_sel, apu_sel, pad0_rd, pad1_rd, pad_strobe_wr, dma_start, cart_sel};
        exp_f = {r == 1, r == 2, r == 3, r == 4, r == 5, r == 6, r == 8};
        ok = (act_f == exp_f);
        if (r == 1) ok = ok && (vid_idx == a[2:0]);
        if (r == 2) ok = ok && (apu_idx == a[4:0]);
        if (r == 5) ok = ok && (pad_strobe == d[0]);
        if (r == 6) ok = ok && (dma_page == d);
        if (r == 8) ok = ok && (cart_addr == a);
        if (w) ok = ok && bus_wr && (bus_wdata == d);
        check(ok, tag_of(r), {8'(act_f), a}, {8'(exp_f), a});
    endtask

    task automatic do_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1 check_sel(a, 1'b0, 8'h00);
        @(posedge clk);
        #1 check(cpu_rdata == exp_read(a), {tag_of(region_of(a, 1'b0)), " rdata"},
                 32'(cpu_rdata), 32'(exp_read(a)));
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input bit chk);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_wdata = d;
        if (chk) begin
            #1 check_sel(a, 1'b1, d);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic do_idle();
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        cpu_addr = 16'h0000; cpu_wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'(total), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vid_vblank = 1'b0;
        apply_reset();
        #1;
        // R11: reset state
        check(cpu_rdata == 8'h00, "R11 rdata", 32'(cpu_rdata), 32'h0);
        check(test_err == 1'b0, "R11 test_err", 32'(test_err), 32'h0);
        check(nmi_req == 1'b0, "R11 nmi_req", 32'(nmi_req), 32'h0);

        // R1: fill RAM through rotating mirrors
        for (int i = 0; i < 2048; i++) begin
            do_write(16'(i + 16'h0800 * (i % 4)), ram_pat(i), 1'b0);
        end

        // Full read sweep except the test range (R1 R2 R3 R4 R9)
        for (int a = 0; a < 65536; a++) begin
            if (a >= 16'h4018 && a < 16'h4020) continue;
            do_read(16'(a));
        end
        check(test_err == 1'b0, "R8 no error outside range", 32'(test_err), 32'h0);

        // Write sweep over the I/O window (R5 R6 R7) with R12 hold check
        do_read(16'h4016);
        for (int a = 16'h4000; a < 16'h4018; a++) begin
            do_write(16'(a), 8'(a) ^ 8'h5C, 1'b1);
            check(cpu_rdata == 8'h5A, "R12 hold on write", 32'(cpu_rdata), 32'h5A);
        end
        do_write(16'h4016, 8'h01, 1'b1);
        do_write(16'h4016, 8'hFE, 1'b1);
        do_idle();
        check(cpu_rdata == 8'h5A, "R12 hold on idle", 32'(cpu_rdata), 32'h5A);

        // R10: interrupt on rising enable during vblank
        vid_vblank = 1'b1;
        do_write(16'h2000, 8'h80, 1'b1);
        check(nmi_req == 1'b1, "R10 rise in vblank", 32'(nmi_req), 32'h1);
        do_idle();
        check(nmi_req == 1'b0, "R10 single pulse", 32'(nmi_req), 32'h0);
        do_write(16'h2000, 8'h80, 1'b1);
        check(nmi_req == 1'b0, "R10 enable already set", 32'(nmi_req), 32'h0);
        do_write(16'h2001, 8'hFF, 1'b1);
        check(nmi_req == 1'b0, "R10 other register", 32'(nmi_req), 32'h0);
        do_write(16'h2000, 8'h00, 1'b1);
        check(nmi_req == 1'b0, "R10 enable cleared", 32'(nmi_req), 32'h0);
        vid_vblank = 1'b0;
        do_write(16'h2008, 8'h80, 1'b1);
        check(nmi_req == 1'b0, "R10 vblank off", 32'(nmi_req), 32'h0);
        do_write(16'h3FF8, 8'h00, 1'b1);
        vid_vblank = 1'b1;
        do_write(16'h3FF8, 8'h80, 1'b1);
        check(nmi_req == 1'b1, "R10 mirror rise", 32'(nmi_req), 32'h1);
        do_write(16'h0000, 8'h80, 1'b1);
        check(nmi_req == 1'b0, "R10 non-video write", 32'(nmi_req), 32'h0);
        vid_vblank = 1'b0;

        // R8: test range access, sticky flag
        do_read(16'h4018);
        check(test_err == 1'b1, "R8 set by read", 32'(test_err), 32'h1);
        do_read(16'h1234);
        do_idle();
        check(test_err == 1'b1, "R8 sticky", 32'(test_err), 32'h1);
        apply_reset();
        #1;
        check(test_err == 1'b0, "R11 error cleared", 32'(test_err), 32'h0);
        do_write(16'h401F, 8'h33, 1'b1);
        check(test_err == 1'b1, "R8 set by write", 32'(test_err), 32'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule